// File: doc/BRIEF.md
# Two-Sided MII Handover Multiplexer

This block sits between one shared MII port and two MAC sets, called side A and side B. During a runtime change of switch implementation, the block moves the port from the side that owns it to the other side without cutting a frame short. The receive path and the transmit path each have their own select. Each select moves at its own safe moment.

A handover request flips the target side. The receive select follows at the first clock edge that falls in an inter-frame gap, and every later frame goes to the target side. The transmit select waits for three things: the side currently transmitting reports that its queue is drained, its transmit enable is low, and a full minimum inter-frame gap has been counted on the shared port. The side that does not own transmit is held in suspend, so frames already queued there cannot leave early. A done flag reports that both paths have arrived on the target side.

A later request starts a handover in the opposite direction, so the port can be moved back and forth. Copying buffered frames between the two sides is left to the surrounding system.

Top module: `mii_handover_mux`

## Requirements
- R1: After reset, `rx_sel` and `tx_sel` are 0 (side A), `done` is 0, `a_tx_hold` is 0 and `b_tx_hold` is 1.
- R2: The receive side named by `rx_sel` (0 = A, 1 = B) sees `mii_rx_dv` and `mii_rxd` unchanged. The other side sees a valid of 0 and data of 0.
- R3: After an accepted request, `rx_sel` takes the new target at the first clock edge, one cycle or more after acceptance, at which `mii_rx_dv` is low. It never changes at an edge where `mii_rx_dv` is high.
- R4: `mii_tx_en` and `mii_txd` are taken from side A when `tx_sel` is 0 and from side B when `tx_sel` is 1.
- R5: `tx_sel` changes only at an edge where `live_tx_drained` is high and `mii_tx_en` is low.
- R6: `tx_sel` changes only at an edge that ends at least IFG_CLKS (default 24) consecutive cycles of `mii_tx_en` low. The shared port counts as idle since long before reset.
- R7: The transmit side not named by `tx_sel` has its hold output at 1, and the named side has its hold output at 0.
- R8: `done` rises one cycle after both selects equal the target following an accepted request. It stays high until the next accepted request, and falls on the edge that accepts that request.
- R9: A request is accepted only when no handover is in progress. A request that arrives during a handover has no effect.
- R10: Each accepted request flips the target side, so successive handovers alternate A to B, then B to A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | MII-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| swap_req | input | 1 | One-cycle request to move the port to the other side |
| mii_rx_dv | input | 1 | Receive data valid from the PHY |
| mii_rxd | input | DATA_W | Receive nibble from the PHY |
| a_rx_dv | output | 1 | Receive valid to side A |
| a_rxd | output | DATA_W | Receive data to side A |
| b_rx_dv | output | 1 | Receive valid to side B |
| b_rxd | output | DATA_W | Receive data to side B |
| a_tx_en | input | 1 | Transmit enable from side A |
| a_txd | input | DATA_W | Transmit data from side A |
| b_tx_en | input | 1 | Transmit enable from side B |
| b_txd | input | DATA_W | Transmit data from side B |
| live_tx_drained | input | 1 | The side that owns transmit has an empty queue |
| mii_tx_en | output | 1 | Transmit enable to the PHY |
| mii_txd | output | DATA_W | Transmit nibble to the PHY |
| a_tx_hold | output | 1 | Suspend for side A's transmitter |
| b_tx_hold | output | 1 | Suspend for side B's transmitter |
| rx_sel | output | 1 | Current receive owner (0 = A, 1 = B) |
| tx_sel | output | 1 | Current transmit owner (0 = A, 1 = B) |
| done | output | 1 | Both paths are on the target side |

## Verification
The properties take for granted that every input is synchronous to `clk` and carries a known value once reset is released. They also take for granted that `live_tx_drained` describes whichever side currently owns transmit. The gap property counts idle cycles on the shared `mii_tx_en` alone, so it holds for any pattern of frames. The stimulus changes inputs only just after the falling edge. It drives frame-like runs of valid and enable together with sparse requests, and it keeps the drain status mostly high so that handovers complete often. It also places some requests inside frames and some inside running handovers.

// File: rtl/mii_ho_pkg.sv
package mii_ho_pkg;
   typedef enum logic {
      SIDE_A = 1'b0,
      SIDE_B = 1'b1
   } side_e;
endpackage

// File: rtl/mii_ho_seq.sv
// Handover sequencer: accepts requests, owns the target side and the done flag.
module mii_ho_seq
   import mii_ho_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  swap_req,
   input  side_e rx_sel,
   input  side_e tx_sel,
   output side_e target,
   output logic  done
);
   logic busy_q;
   logic accept;
   logic arrived;

   assign accept  = swap_req && !busy_q;
   assign arrived = busy_q && (rx_sel == target) && (tx_sel == target);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         target <= SIDE_A;
         busy_q <= 1'b0;
         done   <= 1'b0;
      end else if (accept) begin
         target <= side_e'(~target);
         busy_q <= 1'b1;
         done   <= 1'b0;
      end else if (arrived) begin
         busy_q <= 1'b0;
         done   <= 1'b1;
      end
   end
endmodule

// File: rtl/mii_ho_rx_route.sv
// Receive select and fan-out: moves only inside an inter-frame gap.
module mii_ho_rx_route
   import mii_ho_pkg::*;
#(
   parameter int DATA_W         = 4,
   parameter bit ZERO_IDLE_DATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  side_e             target,
   input  logic              mii_rx_dv,
   input  logic [DATA_W-1:0] mii_rxd,
   output side_e             rx_sel,
   output logic              a_rx_dv,
   output logic [DATA_W-1:0] a_rxd,
   output logic              b_rx_dv,
   output logic [DATA_W-1:0] b_rxd
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rx_sel <= SIDE_A;
      else if ((rx_sel != target) && !mii_rx_dv)
         rx_sel <= target;
   end

   assign a_rx_dv = mii_rx_dv && (rx_sel == SIDE_A);
   assign b_rx_dv = mii_rx_dv && (rx_sel == SIDE_B);

   generate
      if (ZERO_IDLE_DATA) begin : g_zero
         assign a_rxd = (rx_sel == SIDE_A) ? mii_rxd : '0;
         assign b_rxd = (rx_sel == SIDE_B) ? mii_rxd : '0;
      end else begin : g_bcast
         assign a_rxd = mii_rxd;
         assign b_rxd = mii_rxd;
      end
   endgenerate
endmodule

// File: rtl/mii_ho_tx_gate.sv
// Transmit select: waits for drain, idle enable and a full minimum gap.
module mii_ho_tx_gate
   import mii_ho_pkg::*;
#(
   parameter int DATA_W   = 4,
   parameter int IFG_CLKS = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  side_e             target,
   input  logic              live_tx_drained,
   input  logic              a_tx_en,
   input  logic [DATA_W-1:0] a_txd,
   input  logic              b_tx_en,
   input  logic [DATA_W-1:0] b_txd,
   output logic              mii_tx_en,
   output logic [DATA_W-1:0] mii_txd,
   output side_e             tx_sel,
   output logic              a_tx_hold,
   output logic              b_tx_hold
);
   localparam int CNT_W = $clog2(IFG_CLKS + 1);
   localparam logic [CNT_W-1:0] GAP_FULL = CNT_W'(IFG_CLKS);
   localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(IFG_CLKS - 1);

   logic [CNT_W-1:0] gap_q;
   logic             gap_ok;

   assign mii_tx_en = (tx_sel == SIDE_B) ? b_tx_en : a_tx_en;
   assign mii_txd   = (tx_sel == SIDE_B) ? b_txd   : a_txd;

   // gap_q counts idle cycles already completed; this cycle adds one more
   assign gap_ok = !mii_tx_en && live_tx_drained && (gap_q >= GAP_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         gap_q <= GAP_FULL;
      else if (mii_tx_en)
         gap_q <= '0;
      else if (gap_q != GAP_FULL)
         gap_q <= gap_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tx_sel <= SIDE_A;
      else if ((tx_sel != target) && gap_ok)
         tx_sel <= target;
   end

   assign a_tx_hold = (tx_sel != SIDE_A);
   assign b_tx_hold = (tx_sel != SIDE_B);
endmodule

// File: rtl/mii_handover_mux.sv
module mii_handover_mux
   import mii_ho_pkg::*;
#(
   parameter int DATA_W         = 4,
   parameter int IFG_CLKS       = 24,
   parameter bit ZERO_IDLE_DATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              swap_req,
   input  logic              mii_rx_dv,
   input  logic [DATA_W-1:0] mii_rxd,
   output logic              a_rx_dv,
   output logic [DATA_W-1:0] a_rxd,
   output logic              b_rx_dv,
   output logic [DATA_W-1:0] b_rxd,
   input  logic              a_tx_en,
   input  logic [DATA_W-1:0] a_txd,
   input  logic              b_tx_en,
   input  logic [DATA_W-1:0] b_txd,
   input  logic              live_tx_drained,
   output logic              mii_tx_en,
   output logic [DATA_W-1:0] mii_txd,
   output logic              a_tx_hold,
   output logic              b_tx_hold,
   output logic              rx_sel,
   output logic              tx_sel,
   output logic              done
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be at least 1");
      end
      if (IFG_CLKS < 2) begin : g_bad_gap
         $error("IFG_CLKS must be at least 2");
      end
   endgenerate

   side_e target;
   side_e rx_side;
   side_e tx_side;

   mii_ho_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .swap_req (swap_req),
      .rx_sel   (rx_side),
      .tx_sel   (tx_side),
      .target   (target),
      .done     (done)
   );

   mii_ho_rx_route #(
      .DATA_W         (DATA_W),
      .ZERO_IDLE_DATA (ZERO_IDLE_DATA)
   ) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .target    (target),
      .mii_rx_dv (mii_rx_dv),
      .mii_rxd   (mii_rxd),
      .rx_sel    (rx_side),
      .a_rx_dv   (a_rx_dv),
      .a_rxd     (a_rxd),
      .b_rx_dv   (b_rx_dv),
      .b_rxd     (b_rxd)
   );

   mii_ho_tx_gate #(
      .DATA_W   (DATA_W),
      .IFG_CLKS (IFG_CLKS)
   ) u_tx (
      .clk             (clk),
      .rst_n           (rst_n),
      .target          (target),
      .live_tx_drained (live_tx_drained),
      .a_tx_en         (a_tx_en),
      .a_txd           (a_txd),
      .b_tx_en         (b_tx_en),
      .b_txd           (b_txd),
      .mii_tx_en       (mii_tx_en),
      .mii_txd         (mii_txd),
      .tx_sel          (tx_side),
      .a_tx_hold       (a_tx_hold),
      .b_tx_hold       (b_tx_hold)
   );

   assign rx_sel = rx_side;
   assign tx_sel = tx_side;
endmodule

// File: rtl/mii_handover_chk.sv
module mii_handover_chk #(
   parameter int IFG_CLKS = 24
) (
   input logic clk,
   input logic rst_n,
   input logic swap_req,
   input logic mii_rx_dv,
   input logic mii_tx_en,
   input logic live_tx_drained,
   input logic rx_sel,
   input logic tx_sel,
   input logic a_rx_dv,
   input logic b_tx_hold,
   input logic done
);
   int lo_cnt;
   int lo_now;

   assign lo_now = mii_tx_en ? 0 : ((lo_cnt >= IFG_CLKS) ? IFG_CLKS : lo_cnt + 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lo_cnt <= IFG_CLKS;
      else        lo_cnt <= lo_now;
   end

   AST_RX_ROUTE_A: assert property (@(posedge clk) disable iff (!rst_n)
      a_rx_dv |-> (mii_rx_dv && !rx_sel)); // R2
   AST_RX_IN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rx_sel) |-> !$past(mii_rx_dv)); // R3
   AST_TX_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(tx_sel) |-> ($past(live_tx_drained) && !$past(mii_tx_en))); // R5
   AST_TX_FULL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(tx_sel) |-> ($past(lo_now) >= IFG_CLKS)); // R6
   AST_NEW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_sel) |-> $past(b_tx_hold)); // R7
   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !swap_req) |=> done); // R8
endmodule

bind mii_handover_mux mii_handover_chk #(.IFG_CLKS(IFG_CLKS)) u_chk (.*);

// File: tb/mii_handover_mux_tb.sv
module mii_handover_mux_tb;
   localparam int W   = 4;
   localparam int IFG = 24;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic swap_req = 1'b0;
   logic mii_rx_dv = 1'b0;
   logic [W-1:0] mii_rxd = '0;
   logic a_rx_dv, b_rx_dv;
   logic [W-1:0] a_rxd, b_rxd;
   logic a_tx_en = 1'b0, b_tx_en = 1'b0;
   logic [W-1:0] a_txd = '0, b_txd = '0;
   logic live_tx_drained = 1'b1;
   logic mii_tx_en;
   logic [W-1:0] mii_txd;
   logic a_tx_hold, b_tx_hold, rx_sel, tx_sel, done;

   always #5 clk = ~clk;

   mii_handover_mux #(.DATA_W(W), .IFG_CLKS(IFG)) u_dut (.*);

   int nchk = 0;
   int nerr = 0;
   bit finished = 1'b0;
   bit cmp_on = 1'b0;

   // behavioural reference state
   int m_tgt, m_rx, m_tx, m_busy, m_done, m_gap;

   task automatic chk(input string req, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_tgt = 0; m_rx = 0; m_tx = 0; m_busy = 0; m_done = 0; m_gap = IFG;
      end else begin
         int en, n_tgt, n_rx, n_tx, n_busy, n_done, n_gap;
         en = m_tx ? int'(b_tx_en) : int'(a_tx_en);
         n_tgt = m_tgt; n_rx = m_rx; n_tx = m_tx; n_busy = m_busy; n_done = m_done;
         if (m_rx != m_tgt && !mii_rx_dv) n_rx = m_tgt;
         if (m_tx != m_tgt && live_tx_drained && en == 0 && m_gap + 1 >= IFG) n_tx = m_tgt;
         n_gap = en ? 0 : ((m_gap >= IFG) ? IFG : m_gap + 1);
         if (swap_req && m_busy == 0) begin
            n_tgt = 1 - m_tgt; n_busy = 1; n_done = 0;
         end else if (m_busy == 1 && m_rx == m_tgt && m_tx == m_tgt) begin
            n_busy = 0; n_done = 1;
         end
         m_tgt = n_tgt; m_rx = n_rx; m_tx = n_tx; m_busy = n_busy; m_done = n_done; m_gap = n_gap;
      end
   end

   always @(negedge clk) begin
      if (cmp_on && rst_n) begin
         chk("R2 a_rx_dv", a_rx_dv, (m_rx == 0) ? mii_rx_dv : 0);
         chk("R2 b_rx_dv", b_rx_dv, (m_rx == 1) ? mii_rx_dv : 0);
         chk("R2 a_rxd", a_rxd, (m_rx == 0) ? mii_rxd : 0);
         chk("R2 b_rxd", b_rxd, (m_rx == 1) ? mii_rxd : 0);
         chk("R3 rx_sel", rx_sel, m_rx);
         chk("R4 mii_tx_en", mii_tx_en, m_tx ? b_tx_en : a_tx_en);
         chk("R4 mii_txd", mii_txd, m_tx ? b_txd : a_txd);
         chk("R5 R6 tx_sel", tx_sel, m_tx);
         chk("R7 a_tx_hold", a_tx_hold, m_tx);
         chk("R7 b_tx_hold", b_tx_hold, 1 - m_tx);
         chk("R8 R9 R10 done", done, m_done);
      end
   end

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic pulse_req();
      swap_req = 1'b1;
      step();
      swap_req = 1'b0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      nerr++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      int waited;
      repeat (3) step();
      rst_n = 1'b1;
      step();
      // R1 reset state
      chk("R1 rx_sel", rx_sel, 0);
      chk("R1 tx_sel", tx_sel, 0);
      chk("R1 done", done, 0);
      chk("R1 a_tx_hold", a_tx_hold, 0);
      chk("R1 b_tx_hold", b_tx_hold, 1);
      cmp_on = 1'b1;

      // request in the middle of a received frame: rx waits for valid low
      mii_rx_dv = 1'b1; mii_rxd = 4'h5;
      step();
      pulse_req();
      repeat (4) begin
         step();
         chk("R3 held during frame", rx_sel, 0);
      end
      mii_rx_dv = 1'b0;
      step();
      chk("R3 moves in gap", rx_sel, 1);
      repeat (3) step();
      chk("R8 done after A to B", done, 1);
      chk("R10 tx on B", tx_sel, 1);

      // back to A while B transmits: gap length measured
      b_tx_en = 1'b1; b_txd = 4'hA;
      repeat (3) step();
      pulse_req();
      chk("R8 done cleared", done, 0);
      // second request during handover: ignored (R9)
      pulse_req();
      b_tx_en = 1'b0;
      waited = 0;
      while (tx_sel == 1'b1 && waited < 100) begin
         step();
         waited++;
      end
      chk("R6 idle cycles before switch", waited, IFG);
      repeat (3) step();
      chk("R9 single toggle rx", rx_sel, 0);
      chk("R9 single toggle tx", tx_sel, 0);
      chk("R8 done after B to A", done, 1);

      // drain status low blocks transmit switch (R5)
      live_tx_drained = 1'b0;
      pulse_req();
      repeat (IFG + 5) step();
      chk("R5 blocked by drain", tx_sel, 0);
      live_tx_drained = 1'b1;
      repeat (3) step();
      chk("R5 released", tx_sel, 1);

      // random traffic, compared every cycle
      for (int i = 0; i < 4000; i++) begin
         if ($urandom_range(0, 9) == 0) mii_rx_dv = ~mii_rx_dv;
         mii_rxd = W'($urandom);
         if ($urandom_range(0, 11) == 0) a_tx_en = ~a_tx_en;
         if ($urandom_range(0, 11) == 0) b_tx_en = ~b_tx_en;
         a_txd = W'($urandom);
         b_txd = W'($urandom);
         live_tx_drained = ($urandom_range(0, 7) != 0);
         swap_req = ($urandom_range(0, 39) == 0);
         step();
      end
      swap_req = 1'b0;
      step();
      finish_run();
   end
endmodule